// File: doc/BRIEF.md
# Eight-Channel Conversion Result Readout Port

This block is the device-side readout path for a bank of eight 14-bit conversion results. A conversion engine presents all eight results as one flat parallel word. The block captures them when its busy input falls. A host then reads them back with active-low chip-select and read strobes. Every new access shows the next channel, so a run of strobes walks through the bank in a fixed order.

In word mode each access places a full sign-extended 16-bit value on the bus. In byte mode each result takes two 8-bit accesses on the low half of the bus. A byte-order input chooses whether the upper or the lower half of the result comes first. A first-data flag marks the accesses that carry channel 1. The bus is driven only during an access, and the block exposes an output-enable for the pad tri-state. All strobes are sampled on the system clock. An access starts on the first clock at which chip-select and read are both sampled low, and it ends when either one is sampled high.

The sequencer has three states. `ST_ARMED` means the bus is released and the next access shows the current pointer without moving it. `ST_SHOW` means the bus is driven. `ST_GAP` means the bus is released and the next access advances the pointer. Its transitions are:
- **start-armed**: `ST_ARMED` to `ST_SHOW` when an access starts.
- **end**: `ST_SHOW` to `ST_GAP` when the access ends.
- **start-advance**: `ST_GAP` to `ST_SHOW` when an access starts; the pointer steps forward.
- **load**: any state to `ST_ARMED` on a busy fall. This transition takes priority over the others.

Top module: `chan_result_reader`

## Requirements
- R1: `bus_oe` is high exactly in the cycle after `cs_n` and `rd_n` were both sampled low, and stays high until a cycle after either is sampled high. While `bus_oe` is low, `bus_out` is all zeros.
- R2: In word mode (`byte_mode`=0), `bus_out[13:0]` is the channel result, and `bus_out[15]` and `bus_out[14]` both equal result bit 13.
- R3: After a load, the first access shows channel 1, which is bits 13..0 of `load_data`. Each further access shows the next channel, so the eighth shows channel 8, which is bits 111..98.
- R4: In byte mode (`byte_mode`=1), each access carries one byte on `bus_out[7:0]`, with `bus_out[15:8]` at zero. Two accesses cover one channel, so sixteen cover all eight.
- R5: In byte mode, `hi_first`=1 sends the upper byte first and `hi_first`=0 sends the lower byte first. The upper byte is {bit13, bit13, bits 13..8} of the result, and the lower byte is bits 7..0.
- R6: `first_data` is high exactly while the bus is driven with channel 1, in word mode and for both bytes in byte mode.
- R7: A busy fall (`busy` sampled 1 then 0) captures `load_data`, returns the pointer to channel 1 and the first byte, and releases the bus even if an access is in progress. The next access then shows channel 1.
- R8: While `busy` is high, changes on `load_data` have no effect, and reads return the previously captured results.
- R9: An access after channel 8 (after its second byte in byte mode) wraps back to channel 1.
- R10: `cs_n` and `rd_n` may toggle together as one signal, and each combined falling edge both enables the bus and advances the channel. Out of reset the bank is zero and the first access shows channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Conversion in progress; its fall loads new results |
| load_data | input | 112 | Eight 14-bit results, channel 1 in the lowest bits |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| byte_mode | input | 1 | 1 = two 8-bit transfers per channel, 0 = one 16-bit transfer |
| hi_first | input | 1 | Byte mode order: 1 = upper byte first |
| bus_out | output | 16 | Read data |
| bus_oe | output | 1 | Drive enable for the data bus pads |
| first_data | output | 1 | High while channel 1 is on the bus |

## Verification
The stimulus runs word reads with chip-select held low and only read pulsing. This separates the access-start detection from the chip-select gating. Combined strobes check that one edge both enables and advances. Byte reads run with each byte order, which exposes a swapped half select or a missing sign extension in the upper byte. Results with bit 13 alternating per channel distinguish sign extension from zero fill. Reads during busy with fresh `load_data`, and a busy fall in the middle of an access, tell early capture and a stale pointer apart from correct loading. Runs past channel 8 expose wrap faults.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_SHOW  = 2'd1,
        ST_GAP   = 2'd2
    } rd_state_e;

endpackage

// File: rtl/rdo_bank.sv
module rdo_bank #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 14,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en,
    input  logic [NUM_CH*RES_W-1:0]   load_data,
    input  logic [IDX_W-1:0]          idx,
    output logic [RES_W-1:0]          result
);

    logic [RES_W-1:0] mem [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[c] <= '0;
            end else if (load_en) begin
                mem[c] <= load_data[c*RES_W +: RES_W];
            end
        end
    end

    assign result = mem[idx];

endmodule

// File: rtl/rdo_seq.sv
module rdo_seq
    import rdo_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             byte_mode,
    output logic             load_en,
    output logic [IDX_W-1:0] idx,
    output logic             phase,
    output logic             show
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

    rd_state_e        state, state_n;
    logic [IDX_W-1:0] idx_n;
    logic             phase_n;
    logic             act, act_q, busy_q;
    logic             acc_start, acc_end, busy_fall;

    assign act = !cs_n && !rd_n;

    // Edge history follows the inputs even in reset so a busy fall is
    // judged against the true previous sample.
    always_ff @(posedge clk) begin
        act_q  <= act;
        busy_q <= busy;
    end

    assign acc_start = act && !act_q;
    assign acc_end   = !act && act_q;
    assign busy_fall = !busy && busy_q;

    always_comb begin
        state_n = state;
        idx_n   = idx;
        phase_n = phase;
        if (busy_fall) begin
            state_n = ST_ARMED;
            idx_n   = '0;
            phase_n = 1'b0;
        end else begin
            unique case (state)
                ST_ARMED: if (acc_start) state_n = ST_SHOW;
                ST_SHOW:  if (acc_end)   state_n = ST_GAP;
                ST_GAP: begin
                    if (acc_start) begin
                        state_n = ST_SHOW;
                        if (byte_mode && !phase) begin
                            phase_n = 1'b1;
                        end else begin
                            phase_n = 1'b0;
                            idx_n   = (idx == LAST) ? '0 : idx + 1'b1;
                        end
                    end
                end
                default: state_n = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_ARMED;
            idx   <= '0;
            phase <= 1'b0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            phase <= phase_n;
        end
    end

    always_comb begin
        show    = (state == ST_SHOW);
        load_en = busy_fall;
    end

endmodule

// File: rtl/rdo_fmt.sv
module rdo_fmt #(
    parameter int RES_W = 14,
    parameter int BUS_W = 16,
    localparam int HALF = BUS_W / 2
) (
    input  logic [RES_W-1:0] result,
    input  logic             phase,
    input  logic             byte_mode,
    input  logic             hi_first,
    input  logic             show,
    output logic [BUS_W-1:0] bus_out
);

    logic [BUS_W-1:0] wide;
    logic             take_hi;

    assign wide    = {{(BUS_W-RES_W){result[RES_W-1]}}, result};
    assign take_hi = hi_first ^ phase;

    always_comb begin
        if (!show) begin
            bus_out = '0;
        end else if (byte_mode) begin
            bus_out = {{HALF{1'b0}}, take_hi ? wide[BUS_W-1:HALF] : wide[HALF-1:0]};
        end else begin
            bus_out = wide;
        end
    end

endmodule

// File: rtl/chan_result_reader.sv
module chan_result_reader #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 14,
    parameter int BUS_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy,
    input  logic [NUM_CH*RES_W-1:0] load_data,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    byte_mode,
    input  logic                    hi_first,
    output logic [BUS_W-1:0]        bus_out,
    output logic                    bus_oe,
    output logic                    first_data
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic             load_en, phase, show;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] result;

    rdo_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .rd_n(rd_n),
        .byte_mode(byte_mode), .load_en(load_en), .idx(idx),
        .phase(phase), .show(show)
    );

    rdo_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_data(load_data),
        .idx(idx), .result(result)
    );

    rdo_fmt #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
        .result(result), .phase(phase), .byte_mode(byte_mode),
        .hi_first(hi_first), .show(show), .bus_out(bus_out)
    );

    assign bus_oe     = show;
    assign first_data = show && (idx == '0);

endmodule

// File: rtl/chan_result_reader_chk.sv
module chan_result_reader_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cs_n,
    input logic             rd_n,
    input logic             byte_mode,
    input logic [BUS_W-1:0] bus_out,
    input logic             bus_oe,
    input logic             first_data
);

    a_r1_drive_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!$past(cs_n) && !$past(rd_n)));

    a_r1_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));

    a_r2_word_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && !byte_mode) |-> (bus_out[15] == bus_out[13] && bus_out[14] == bus_out[13]));

    a_r4_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && byte_mode) |-> (bus_out[BUS_W-1:BUS_W/2] == '0));

    a_r6_flag_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        first_data |-> bus_oe);

    a_r7_release_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> !bus_oe);

endmodule

bind chan_result_reader chan_result_reader_chk #(.BUS_W(BUS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .rd_n(rd_n),
    .byte_mode(byte_mode), .bus_out(bus_out), .bus_oe(bus_oe),
    .first_data(first_data)
);

// File: tb/chan_result_reader_tb_top.sv
`timescale 1ns/1ps
module chan_result_reader_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         busy = 1'b0;
    logic [111:0] load_data = '0;
    logic         cs_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         byte_mode = 1'b0;
    logic         hi_first = 1'b1;
    logic [15:0]  bus_out;
    logic         bus_oe;
    logic         first_data;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    chan_result_reader dut_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .load_data(load_data),
        .cs_n(cs_n), .rd_n(rd_n), .byte_mode(byte_mode), .hi_first(hi_first),
        .bus_out(bus_out), .bus_oe(bus_oe), .first_data(first_data)
    );

    // Behavioural reference
    int m_bank[8];
    int m_ch = 0;
    int m_ph = 0;
    bit m_on = 0;
    bit m_fresh = 1;
    bit m_act_q = 0;
    bit m_busy_q = 0;

    initial foreach (m_bank[i]) m_bank[i] = 0;

    always @(posedge clk) begin
        bit act;
        act = !cs_n && !rd_n;
        if (!rst_n) begin
            foreach (m_bank[i]) m_bank[i] = 0;
            m_ch = 0; m_ph = 0; m_on = 0; m_fresh = 1;
        end else if (m_busy_q && !busy) begin
            for (int i = 0; i < 8; i++) m_bank[i] = int'(load_data[i*14 +: 14]);
            m_ch = 0; m_ph = 0; m_on = 0; m_fresh = 1;
        end else if (act && !m_act_q) begin
            if (!m_fresh) begin
                if (byte_mode && m_ph == 0) m_ph = 1;
                else begin m_ph = 0; m_ch = (m_ch + 1) % 8; end
            end
            m_fresh = 0;
            m_on = 1;
        end else if (!act && m_act_q) begin
            m_on = 0;
        end
        m_act_q  = act;
        m_busy_q = busy;
    end

    function automatic int exp_bus();
        int w;
        bit hi;
        if (!m_on) return 0;
        w = m_bank[m_ch];
        if (w & 'h2000) w = w | 'hC000;
        if (!byte_mode) return w;
        hi = (m_ph == 0) == hi_first;
        return hi ? ((w >> 8) & 'hFF) : (w & 'hFF);
    endfunction

    always @(negedge clk) begin
        int eb;
        bit ef;
        if (!done) begin
            eb = exp_bus();
            ef = m_on && (m_ch == 0);
            n_tests++;
            if (bus_oe !== m_on || int'(bus_out) != eb || first_data !== ef) begin
                n_fail++;
                $display("FAIL %s: oe=%0b data=%h first=%0b, expected oe=%0b data=%h first=%0b",
                         cur_req, bus_oe, bus_out, first_data, m_on, eb[15:0], ef);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input bit comb);
        step(); rd_n = 1'b0; if (comb) cs_n = 1'b0;
        step(); step();
        rd_n = 1'b1; if (comb) cs_n = 1'b1;
        step();
    endtask

    function automatic logic [111:0] make_data(input bit alt_sign);
        logic [111:0] d;
        for (int i = 0; i < 8; i++) begin
            d[i*14 +: 14] = 14'($urandom);
            if (alt_sign) d[i*14 + 13] = i[0];
        end
        return d;
    endfunction

    task automatic convert(input logic [111:0] d);
        step(); busy = 1'b1;
        step(); load_data = make_data(0);
        step(); busy = 1'b0; load_data = d;
        step(); load_data = make_data(0);
        step();
    endtask

    initial begin
        cur_req = "R1";
        repeat (4) step();
        rst_n = 1'b1;
        step();

        cur_req = "R10";               // combined strobe out of reset, zero bank
        pulse(1); pulse(1);

        cur_req = "R7";
        convert(make_data(1));
        cur_req = "R3";                // cs held low, rd pulsed
        cs_n = 1'b0;
        repeat (8) pulse(0);
        cur_req = "R9";
        repeat (3) pulse(0);
        cs_n = 1'b1;

        cur_req = "R8";                // busy high, new data ignored
        step(); busy = 1'b1;
        step(); load_data = make_data(1);
        cs_n = 1'b0;
        repeat (3) pulse(0);
        cs_n = 1'b1;
        step();
        cur_req = "R7";                // load mid access
        step(); rd_n = 1'b0; cs_n = 1'b0;
        step(); step(); busy = 1'b0;
        step(); step(); rd_n = 1'b1; cs_n = 1'b1;
        step();
        pulse(1); pulse(1);

        cur_req = "R5";
        byte_mode = 1'b1; hi_first = 1'b1;
        convert(make_data(1));
        cur_req = "R4";
        cs_n = 1'b0;
        repeat (18) pulse(0);
        cs_n = 1'b1;
        cur_req = "R5";
        hi_first = 1'b0;
        convert(make_data(1));
        repeat (17) pulse(1);

        cur_req = "R2";
        byte_mode = 1'b0; hi_first = 1'b1;
        convert(make_data(1));
        repeat (9) pulse(1);
        cur_req = "R6";
        convert(make_data(0));
        repeat (10) pulse(1);
        repeat (3) step();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL %s: watchdog expired, actual running, expected finished", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule